// File: doc/BRIEF.md
# Asynchronous static RAM access controller

This block lets clocked logic use an asynchronous static RAM with an 18-bit address and a 4-bit data bus. A user side presents one request at a time: a word address, a direction flag and write data. The controller sequences the memory's chip select, write strobe and output enable, and it controls the data pin drivers. Every nanosecond minimum of the memory becomes a whole number of clock cycles, worked out at elaboration time by rounding up.

Writes are timed by the write strobe. Output enable stays high for the whole write, so the memory never drives the pins while the write strobe is low, and the plain minimum pulse width applies. A read leaves the memory driving the pins for a while after its output enable rises. The controller therefore holds back its own drivers until a turnaround count of idle cycles has passed since the last read strobe.

The bidirectional pins are split into an output value, an output enable and an input value, so a pad-level tri-state buffer can sit outside the block.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and right after reset, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `ready` is 1 and `rvalid` is 0.
- R2: A request is accepted only on a clock edge where `ready` is 1 and `req` is 1. A `req` raised while `ready` is 0 starts no memory access, and nothing is written at its address.
- R3: A read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC cycles, where RD_CYC is the larger of ceil(T_ACC_PS/CLK_PS) and ceil(T_RC_PS/CLK_PS) (3 by default). The pin data is captured on the edge that ends the last of these cycles. `rdata` then holds it in the single cycle in which `rvalid` is 1.
- R4: A write first holds `mem_cs_n`=0 with `mem_we_n`=1 for at least one cycle. It then holds `mem_we_n` at 0 for exactly WEL_CYC cycles, where WEL_CYC is the largest of ceil(T_WP_PS/CLK_PS), ceil(T_DS_PS/CLK_PS), ceil(T_AW_PS/CLK_PS)-1 and ceil(T_WC_PS/CLK_PS)-2 (2 by default). It ends with one cycle of `mem_we_n`=1 and `mem_cs_n`=0.
- R5: `mem_we_n` and `mem_oe_n` are never 0 in the same cycle, and `mem_oe_n` is 1 for the whole of every write.
- R6: `mem_dq_oe` is 1 in every cycle where `mem_we_n` is 0, and in the one recovery cycle after it. While `mem_dq_oe` is 1, `mem_dq_out` equals the write data that was accepted with the request.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. It rises only after at least TURN_CYC = ceil(T_TURN_PS/CLK_PS) full cycles (2 by default) with `mem_oe_n` at 1 since the last read strobe.
- R8: `mem_addr` stays unchanged in every cycle where `mem_cs_n` stays 0.
- R9: `ready` is 1 exactly in the cycles where `mem_cs_n` is 1.
- R10: Data written to an address is returned by a later read of that address. This holds for the lowest address 0x00000 and the highest address 0x3FFFF, and for a write issued right after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, taken when `ready` is 1 |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 18 | Word address of the request |
| req_wdata | input | 4 | Data for a write request |
| ready | output | 1 | Controller idle, able to take a request |
| rvalid | output | 1 | One-cycle pulse marking read data |
| rdata | output | 4 | Captured read data |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 4 | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Enable of the data pin drivers |
| mem_dq_in | input | 4 | Value read from the data pins |

## Verification
The bench builds the block with its default parameters: an 18-bit address, a 4-bit word and a 5000 ps clock, with nanosecond minimums that give 3 read cycles, 2 write-strobe cycles and 2 turnaround cycles. Because these counts are small and distinct, a behavioural memory model can give valid data only after exactly the access count. That exposes any capture made one cycle too early. Sequences of a read followed at once by a write run straight into the turnaround wait, and the two end addresses of the 18-bit space test that the address is carried at full width.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WREC
  } seq_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_busguard.sv
module sram_seq_busguard #(
  parameter int TURN_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_active,
  output logic bus_free
);

  localparam int CW = $clog2(TURN_CYC + 1);
  localparam logic [CW-1:0] TURN_LAST = CW'(TURN_CYC);

  logic [CW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (rst)
      quiet_q <= TURN_LAST;
    else if (rd_active)
      quiet_q <= '0;
    else if (quiet_q != TURN_LAST)
      quiet_q <= quiet_q + 1'b1;
  end

  assign bus_free = (quiet_q == TURN_LAST);

  // R7: a read strobe closes the bus to our drivers on the next cycle
  assert_guard_block_R7: assert property (@(posedge clk) disable iff (rst)
    rd_active |=> !bus_free);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int RD_CYC  = 3,
  parameter int WEL_CYC = 2,
  parameter int CNT_W   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_wr,
  input  logic bus_free,
  output logic accept,
  output logic capture,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe,
  output logic ready
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WEL_CYC - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          cnt_d   = '0;
          state_d = req_wr ? ST_WSET : ST_RD;
        end
      end
      ST_RD: begin
        if (cnt_q == RD_LAST) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WSET: begin
        if (bus_free) begin
          cnt_d   = '0;
          state_d = ST_WPUL;
        end
      end
      ST_WPUL: begin
        if (cnt_q == WE_LAST)
          state_d = ST_WREC;
        else
          cnt_d = cnt_q + 1'b1;
      end
      ST_WREC: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cs_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      ready   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cs_n    <= (state_d == ST_IDLE);
      we_n    <= (state_d != ST_WPUL);
      oe_n    <= (state_d != ST_RD);
      dq_oe   <= (state_d == ST_WPUL) || (state_d == ST_WREC);
      ready   <= (state_d == ST_IDLE);
    end
  end

  // R5: the write strobe and output enable never overlap
  assert_oe_we_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n));

  // R4: chip select is already low the cycle before the write strobe falls
  assert_we_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> $past(!cs_n));

  // R4: chip select stays low in the cycle the write strobe rises
  assert_we_recover_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> !cs_n);

  // R7: our drivers are off whenever the memory may be driving
  assert_drive_no_oe_R7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture;
      if (capture)
        rdata <= mem_dq_in;
    end
  end

  // R3: read data is marked by a single-cycle pulse
  assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 4,
  parameter int CLK_PS    = 5000,
  parameter int T_ACC_PS  = 12000,
  parameter int T_RC_PS   = 12000,
  parameter int T_WC_PS   = 12000,
  parameter int T_WP_PS   = 10000,
  parameter int T_AW_PS   = 10000,
  parameter int T_DS_PS   = 7000,
  parameter int T_TURN_PS = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC   = imax(1, imax(cdiv(T_ACC_PS, CLK_PS), cdiv(T_RC_PS, CLK_PS)));
  localparam int WEL_CYC  = imax(1, imax(imax(cdiv(T_WP_PS, CLK_PS), cdiv(T_DS_PS, CLK_PS)),
                                         imax(cdiv(T_AW_PS, CLK_PS) - 1, cdiv(T_WC_PS, CLK_PS) - 2)));
  localparam int TURN_CYC = imax(1, cdiv(T_TURN_PS, CLK_PS));
  localparam int CNT_W    = $clog2(imax(RD_CYC, WEL_CYC) + 1);

  logic accept, capture, bus_free;

  sram_seq_fsm #(
    .RD_CYC (RD_CYC),
    .WEL_CYC(WEL_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .req_wr  (req_wr),
    .bus_free(bus_free),
    .accept  (accept),
    .capture (capture),
    .cs_n    (mem_cs_n),
    .we_n    (mem_we_n),
    .oe_n    (mem_oe_n),
    .dq_oe   (mem_dq_oe),
    .ready   (ready)
  );

  sram_seq_busguard #(
    .TURN_CYC(TURN_CYC)
  ) u_guard (
    .clk      (clk),
    .rst      (rst),
    .rd_active(!mem_cs_n && !mem_oe_n),
    .bus_free (bus_free)
  );

  sram_seq_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .rdata     (rdata),
    .rvalid    (rvalid)
  );

  // R8: the address does not move while the part stays selected
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R9: the user side sees idle exactly when the memory is deselected
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (rst)
    ready == mem_cs_n);

  // R6: a low write strobe always has the data drivers on
  assert_we_driven_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

endmodule

// File: tb/test_sram_seq_ctrl.sv
`timescale 1ns/1ps
module test_sram_seq_ctrl;

  localparam int AW = 18;
  localparam int DW = 4;
  // expected cycle counts, from the nanosecond minimums at a 5 ns clock
  localparam int EXP_RD   = 3;  // 12 ns / 5 ns rounded up
  localparam int EXP_WEL  = 2;  // 10 ns and 7 ns / 5 ns rounded up
  localparam int EXP_TURN = 2;  // 6 ns / 5 ns rounded up

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready, rvalid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rdata, mem_dq_out;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] dq_in_r = '0;

  always #2.5 clk = ~clk;

  sram_seq_ctrl i_sram_seq_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rvalid(rvalid), .rdata(rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(dq_in_r)
  );

  int vec = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural memory and reference contents
  logic [DW-1:0] sram_arr [int];
  logic [DW-1:0] ref_arr  [int];
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] last_wdata = '0;

  int   acc_run = 0, we_run = 0, oe_run = 0, oe_last = 0, since_rd = 1000;
  logic prev_cs_n = 1, prev_we_n = 1, prev_oe_n = 1, prev_dq_oe = 0, prev_rvalid = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dq = '0;

  always @(negedge clk) begin
    if (!rst) begin
      // memory model: write lands as the strobe rises
      if (!prev_we_n && mem_we_n && !mem_cs_n)
        sram_arr[int'(mem_addr)] = prev_dq;
      if (!mem_cs_n && !mem_oe_n && mem_we_n) acc_run++; else acc_run = 0;
      begin
        logic [DW-1:0] v;
        v = sram_arr.exists(int'(mem_addr)) ? sram_arr[int'(mem_addr)] : '0;
        dq_in_r = (acc_run >= EXP_RD) ? v : ~v;
      end

      chk(ready == mem_cs_n, "R9 ready vs select", ready, mem_cs_n);
      chk(!(!mem_we_n && !mem_oe_n), "R5 strobe overlap", {mem_we_n, mem_oe_n}, 2'b11);
      chk(!(mem_dq_oe && !mem_oe_n), "R7 drive during read", mem_dq_oe, 0);
      if (!mem_cs_n && !prev_cs_n)
        chk(mem_addr == prev_addr, "R8 address hold", mem_addr, prev_addr);
      if (mem_dq_oe)
        chk(mem_dq_out == last_wdata, "R6 write data", mem_dq_out, last_wdata);
      if (!mem_we_n) begin
        chk(mem_dq_oe == 1'b1, "R6 drivers during strobe", mem_dq_oe, 1);
        chk(mem_oe_n == 1'b1, "R5 oe high in write", mem_oe_n, 1);
      end
      if (prev_we_n && !mem_we_n)
        chk(prev_cs_n == 1'b0, "R4 select before strobe", prev_cs_n, 0);
      if (!mem_we_n) we_run++;
      if (!prev_we_n && mem_we_n) begin
        chk(we_run == EXP_WEL, "R4 strobe width", we_run, EXP_WEL);
        chk(mem_cs_n == 1'b0, "R4 recovery select", mem_cs_n, 0);
        chk(mem_dq_oe == 1'b1, "R6 recovery drive", mem_dq_oe, 1);
        we_run = 0;
      end
      if (mem_dq_oe && !prev_dq_oe)
        chk(since_rd >= EXP_TURN, "R7 turnaround", since_rd, EXP_TURN);
      if (!mem_oe_n) since_rd = 0; else since_rd++;
      if (!mem_oe_n) oe_run++;
      else if (!prev_oe_n) begin oe_last = oe_run; oe_run = 0; end

      if (rvalid) begin
        chk(!prev_rvalid, "R3 single pulse", prev_rvalid, 0);
        chk(oe_last == EXP_RD, "R3 access length", oe_last, EXP_RD);
        if (exp_q.size() == 0) chk(0, "R3 unexpected rvalid", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rdata == e, "R3/R10 read data", rdata, e);
        end
      end

      // acceptance happens at the coming edge
      if (req && ready) begin
        if (req_wr) begin
          ref_arr[int'(req_addr)] = req_wdata;
          last_wdata = req_wdata;
        end else
          exp_q.push_back(ref_arr.exists(int'(req_addr)) ? ref_arr[int'(req_addr)] : '0);
      end
    end
    prev_cs_n = mem_cs_n; prev_we_n = mem_we_n; prev_oe_n = mem_oe_n;
    prev_dq_oe = mem_dq_oe; prev_rvalid = rvalid; prev_addr = mem_addr; prev_dq = mem_dq_out;
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    while (!ready) begin @(posedge clk); #1; end
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(posedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk({mem_cs_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(mem_dq_oe == 0 && rvalid == 0, "R1 drivers/rvalid in reset", {mem_dq_oe, rvalid}, 0);
    chk(ready == 1, "R1 ready in reset", ready, 1);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready} == 5'b11101, "R1 after reset",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 5'b11101);

    // R10: end addresses of the space
    issue(1, 18'h00000, 4'h5);
    issue(1, 18'h3FFFF, 4'hA);
    issue(0, 18'h00000, 4'h0);
    issue(0, 18'h3FFFF, 4'h0);
    issue(0, 18'h12345, 4'h0);      // never written: reads 0
    // R7/R10: write right after a read
    issue(0, 18'h00000, 4'h0);
    issue(1, 18'h00000, 4'hC);
    issue(0, 18'h00000, 4'h0);

    // R2: request raised while busy is ignored
    issue(1, 18'h00010, 4'h3);
    req = 1'b1; req_wr = 1'b1; req_addr = 18'h2AAAA; req_wdata = 4'hF;
    @(posedge clk); #1;
    req = 1'b0;
    settle();
    @(negedge clk);
    chk(!sram_arr.exists(int'(18'h2AAAA)), "R2 busy request ignored",
        sram_arr.exists(int'(18'h2AAAA)), 0);
    ref_arr.delete(int'(18'h2AAAA));  // bench saw req&&ready? no: ready low, nothing stored
    issue(0, 18'h2AAAA, 4'h0);
    issue(0, 18'h00010, 4'h0);

    // mixed traffic over a few addresses
    begin
      logic [31:0] lf;
      lf = 32'h1ACE_B00C;
      for (int i = 0; i < 80; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        issue(lf[4], {15'h0, lf[7:5]} ^ 18'h2C000, lf[11:8]);
      end
    end
    settle();
    @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule